// File: doc/BRIEF.md
# Six-Step Block-Commutation PWM Controller

This block drives the three high-side and three low-side gate signals of a three-phase bridge for block (trapezoidal) commutation. A free-running counter is compared against a duty value, and every output whose enable is set carries that PWM waveform while every other output is held low. The enables for the next step are prepared ahead of time: either software writes them into a shadow register, or a built-in sequencer supplies them from the standard six-step table. Nothing changes at the pins until a commutation event. At that event, all six enables are loaded into the live register on the same clock edge.

A commutation event comes from a single-cycle software strobe or from a rising edge on an asynchronous trigger pin. A typical system issues one every millisecond. An active-high fault input forces all six outputs low at once. The fault is latched: the outputs stay off after the fault input clears, until a re-arm strobe is given.

The protection logic is a three-state machine. ARMED is the normal running state. ARMED goes to TRIPPED when the fault input is high. TRIPPED goes to REARM_WAIT when the fault input drops. REARM_WAIT goes back to TRIPPED if the fault returns, and goes to ARMED on the re-arm strobe. The outputs are live only in ARMED.

Top module: `sixstep_pwm`

## Requirements
- R1: After reset, all six outputs are low and the sequencer's next step is step 1.
- R2: An enabled output is high exactly in the cycles where the counter is below `duty`, so it is high for `duty` cycles in every period of 2^CNT_W cycles. A disabled output stays at 0.
- R3: A shadow write updates only the bits set in `shd_mask` with the matching `shd_data` bits. Every other shadow bit keeps its previous value. Enable bit order: [0] phase A high, [1] phase B high, [2] phase C high, [3] phase A low, [4] phase B low, [5] phase C low.
- R4: Writing the shadow has no effect on the outputs until a commutation event occurs.
- R5: On a commutation event, all six live enables are loaded on the same clock edge.
- R6: A one-cycle pulse on `com_sw` causes one commutation.
- R7: A rising edge on `com_trig`, after a two-flop synchronizer, causes exactly one commutation three clock edges later. Holding the pin high or letting it fall causes none.
- R8: A software strobe and a trigger edge that land on the same cycle produce a single commutation.
- R9: With `auto_mode` = 1, each commutation applies the sequencer's step and then advances it. The enabled pairs are:
  - step 1: A-high and B-low (0x11)
  - step 2: C-high and B-low (0x14)
  - step 3: C-high and A-low (0x0C)
  - step 4: B-high and A-low (0x0A)
  - step 5: B-high and C-low (0x22)
  - step 6: A-high and C-low (0x21)
- R10: After step 6 the sequencer wraps back to step 1. It advances only on commutations made in auto mode.
- R11: While `brk_in` is high, all six outputs are low in the same cycle, with no clock delay.
- R12: After a fault, the outputs stay low until `brk_in` is low and a `rearm` strobe arrives. A `rearm` given while `brk_in` is still high is ignored.
- R13: In manual mode, a commutation loads the shadow value held before any shadow write in the same cycle. That write takes effect at the next commutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty | input | CNT_W | PWM compare value |
| auto_mode | input | 1 | 1 = enables come from the step sequencer, 0 = from the shadow register |
| shd_wr | input | 1 | Shadow write strobe |
| shd_mask | input | 6 | Per-bit write mask for the shadow register |
| shd_data | input | 6 | Shadow write data |
| com_sw | input | 1 | Software commutation strobe |
| com_trig | input | 1 | Asynchronous commutation trigger, rising edge |
| brk_in | input | 1 | Active-high fault input |
| rearm | input | 1 | Strobe that clears a latched fault |
| out_hi | output | 3 | High-side outputs for phases A, B, C |
| out_lo | output | 3 | Low-side outputs for phases A, B, C |

## Verification
The bench builds the block with CNT_W = 4 and holds `duty` at 5. With these values one PWM period is only 16 cycles. Counting the high cycles of each output over one window then gives the exact duty (5 or 0) without depending on the counter's phase, so the full step table, its wrap and the fault-recovery sequence all fit in a short run. The fixed three-edge synchronizer latency lets the bench place a software strobe on the exact cycle of a trigger edge, which is how the single-commutation case is reached.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;
    localparam int NEN = 6;
    typedef logic [NEN-1:0] en_vec_t;
    typedef enum logic [1:0] {BRK_ARMED, BRK_TRIPPED, BRK_REARM_WAIT} brk_state_e;

    // bit0..2 = A/B/C high side, bit3..5 = A/B/C low side
    function automatic en_vec_t step_pattern(input logic [2:0] s);
        en_vec_t p;
        unique case (s)
            3'd1:    p = 6'h11;
            3'd2:    p = 6'h14;
            3'd3:    p = 6'h0C;
            3'd4:    p = 6'h0A;
            3'd5:    p = 6'h22;
            3'd6:    p = 6'h21;
            default: p = 6'h00;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/sx_pwm_counter.sv
module sx_pwm_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_on,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    always_comb pwm_on = (cnt < duty);

    // R2: counter walks every value once per period
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/sx_commut_src.sv
module sx_commut_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic com_sw,
    input  logic com_trig,
    output logic comm_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   trig_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], com_trig};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        trig_edge = sync_q[SYNC_STAGES-1] & ~prev_q;
        comm_evt  = com_sw | trig_edge;   // R8: merged into one event
    end

    // R7: an edge is reported for one cycle only
    a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_edge |=> !trig_edge);
endmodule

// File: rtl/sx_step_seq.sv
module sx_step_seq
    import sixstep_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    adv,
    output en_vec_t pattern
);
    logic [2:0] step_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      step_q <= 3'd1;
        else if (adv)    step_q <= (step_q == 3'd6) ? 3'd1 : step_q + 3'd1;
    end

    always_comb pattern = step_pattern(step_q);

    a_r10_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q >= 3'd1 && step_q <= 3'd6);
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        adv && step_q == 3'd6 |=> step_q == 3'd1);
    a_r9_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pattern) == 2);
endmodule

// File: rtl/sx_brk_fsm.sv
module sx_brk_fsm
    import sixstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_in,
    input  logic rearm,
    output logic armed
);
    brk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BRK_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRK_ARMED:      if (brk_in) state_d = BRK_TRIPPED;
            BRK_TRIPPED:    if (!brk_in) state_d = BRK_REARM_WAIT;
            BRK_REARM_WAIT: begin
                if (brk_in)     state_d = BRK_TRIPPED;
                else if (rearm) state_d = BRK_ARMED;
            end
            default:        state_d = BRK_TRIPPED;
        endcase
    end

    always_comb armed = (state_q == BRK_ARMED) & ~brk_in;

    // R12: a fault always leaves the machine out of ARMED next cycle
    a_r12_latched: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |=> state_q != BRK_ARMED);
    a_r12_rearm_only: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != BRK_ARMED ##1 state_q == BRK_ARMED |-> $past(rearm) && !$past(brk_in));
endmodule

// File: rtl/sixstep_pwm.sv
module sixstep_pwm
    import sixstep_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty,
    input  logic             auto_mode,
    input  logic             shd_wr,
    input  logic [5:0]       shd_mask,
    input  logic [5:0]       shd_data,
    input  logic             com_sw,
    input  logic             com_trig,
    input  logic             brk_in,
    input  logic             rearm,
    output logic [2:0]       out_hi,
    output logic [2:0]       out_lo
);
    en_vec_t          shadow_q, live_q, seq_pat, gated;
    logic             comm_evt, pwm_on, armed;
    logic [CNT_W-1:0] cnt;

    sx_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .duty(duty), .pwm_on(pwm_on), .cnt(cnt));

    sx_commut_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .com_sw(com_sw), .com_trig(com_trig),
        .comm_evt(comm_evt));

    sx_step_seq u_seq (
        .clk(clk), .rst_n(rst_n), .adv(comm_evt & auto_mode), .pattern(seq_pat));

    sx_brk_fsm u_brk (
        .clk(clk), .rst_n(rst_n), .brk_in(brk_in), .rearm(rearm), .armed(armed));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            if (shd_wr)
                shadow_q <= (shadow_q & ~shd_mask) | (shd_data & shd_mask);
            if (comm_evt)
                live_q <= auto_mode ? seq_pat : shadow_q;   // R5, R13
        end
    end

    always_comb begin
        gated  = (armed && pwm_on) ? live_q : '0;
        out_hi = gated[2:0];
        out_lo = gated[5:3];
    end

    a_r4_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !comm_evt |=> $stable(live_q));
    a_r11_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |-> (out_hi == 3'b000 && out_lo == 3'b000));
    a_r2_duty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (|{out_hi, out_lo}) |-> cnt < duty);
    a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> live_q == '0);
endmodule

// File: tb/sim_sixstep_pwm.sv
`timescale 1ns/1ps
module sim_sixstep_pwm;
    localparam int CNT_W = 4;
    localparam int PER   = 1 << CNT_W;
    localparam int DUTY  = 5;
    localparam int NAUTO = 8;
    // expected live enables after each auto-mode software commutation (R9, R10)
    localparam logic [5:0] AUTO_EXP [NAUTO] =
        '{6'h11, 6'h14, 6'h0C, 6'h0A, 6'h22, 6'h21, 6'h11, 6'h14};

    logic clk = 0, rst_n = 0;
    logic [CNT_W-1:0] duty = DUTY;
    logic auto_mode = 1, shd_wr = 0, com_sw = 0, com_trig = 0, brk_in = 0, rearm = 0;
    logic [5:0] shd_mask = 0, shd_data = 0;
    logic [2:0] out_hi, out_lo;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    sixstep_pwm #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .duty(duty), .auto_mode(auto_mode),
        .shd_wr(shd_wr), .shd_mask(shd_mask), .shd_data(shd_data),
        .com_sw(com_sw), .com_trig(com_trig), .brk_in(brk_in), .rearm(rearm),
        .out_hi(out_hi), .out_lo(out_lo));

    // counts high cycles of each output over one full period and compares to duty
    task automatic measure(input logic [5:0] exp_en, input string req);
        int cnt [6];
        logic [5:0] o;
        bit bad;
        for (int i = 0; i < 6; i++) cnt[i] = 0;
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            o = {out_lo, out_hi};
            for (int i = 0; i < 6; i++) cnt[i] += o[i];
        end
        bad = 0;
        for (int i = 0; i < 6; i++)
            if (cnt[i] != (exp_en[i] ? DUTY : 0)) bad = 1;
        n_run++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: high counts %0d %0d %0d %0d %0d %0d, expected enables %h at duty %0d",
                     req, cnt[0], cnt[1], cnt[2], cnt[3], cnt[4], cnt[5], exp_en, DUTY);
        end
    endtask

    task automatic sw_pulse();
        @(negedge clk) com_sw = 1;
        @(negedge clk) com_sw = 0;
    endtask

    task automatic shd_write(input logic [5:0] m, input logic [5:0] d);
        @(negedge clk) begin shd_wr = 1; shd_mask = m; shd_data = d; end
        @(negedge clk) shd_wr = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        measure(6'h00, "R1 reset outputs low");

        // R6 R9 R10 R5: table of auto-mode commutations, all six checked together
        for (int k = 0; k < NAUTO; k++) begin
            sw_pulse();
            measure(AUTO_EXP[k], "R9 R10 R6 R5 auto step");
        end
        // sequencer next step is now 3

        auto_mode = 0;
        shd_write(6'h3F, 6'h11);
        measure(6'h14, "R4 shadow write has no effect");
        sw_pulse();
        measure(6'h11, "R6 manual commutation loads shadow");
        shd_write(6'h01, 6'h00);
        sw_pulse();
        measure(6'h10, "R3 masked shadow write");

        // R13: write and commutation in the same cycle
        @(negedge clk) begin shd_wr = 1; shd_mask = 6'h3F; shd_data = 6'h0A; com_sw = 1; end
        @(negedge clk) begin shd_wr = 0; com_sw = 0; end
        measure(6'h10, "R13 commutation takes old shadow");
        sw_pulse();
        measure(6'h0A, "R13 new shadow applied next event");

        // R7: trigger edge in auto mode (manual events did not advance the step)
        auto_mode = 1;
        @(negedge clk) com_trig = 1;
        repeat (4) @(negedge clk);
        measure(6'h0C, "R7 trigger edge commutes once");
        measure(6'h0C, "R7 held trigger no further event");
        @(negedge clk) com_trig = 0;
        repeat (4) @(negedge clk);
        measure(6'h0C, "R7 falling trigger no event");

        // R8: strobe placed on the cycle of the trigger edge
        @(negedge clk) com_trig = 1;
        @(negedge clk);
        @(negedge clk) com_sw = 1;
        @(negedge clk) com_sw = 0;
        measure(6'h0A, "R8 coincident events single commutation");
        @(negedge clk) com_trig = 0;
        repeat (4) @(negedge clk);
        sw_pulse();
        measure(6'h22, "R8 following event advances one step");

        // R11 R12: fault forcing and latched recovery
        @(negedge clk) brk_in = 1;
        #1;
        n_run++;
        if ({out_lo, out_hi} != 6'h00) begin
            n_fail++;
            $display("FAIL R11 immediate force: actual %h expected 00", {out_lo, out_hi});
        end
        measure(6'h00, "R11 outputs low under fault");
        @(negedge clk) rearm = 1;
        @(negedge clk) rearm = 0;
        @(negedge clk) brk_in = 0;
        measure(6'h00, "R12 rearm under fault ignored");
        @(negedge clk) rearm = 1;
        @(negedge clk) rearm = 0;
        measure(6'h22, "R12 rearm restores outputs");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule